// File: doc/BRIEF.md
# Memory-Mapped Bus Router with Boot Overlay

This block sits between a single CPU master and the memories and peripherals of a small handheld-style system. The master presents a 16-bit address with a request, a write flag and a word flag. The router decodes the address and steers the access to one downstream port: cartridge, boot ROM, video memory, a fixed work-RAM bank, a switchable work-RAM bank, high RAM or the peripheral register window. It also holds three pieces of system state: the interrupt-enable register, the stored part of the interrupt-flag register, and the boot-overlay latch.

Byte accesses complete in the cycle they are presented, and read data is combinational from the selected source. A word access takes two cycles. The first cycle touches addr+1 and carries the high byte. The second cycle touches addr, carries the low byte, and raises `ready_o`. Any access to a region the system forbids, or to a register in the peripheral window that does not exist, is refused. The refusal is signalled on `bus_err_o`.

Top module: `mem_router`

## Requirements
- R1: Addresses 0x0000–0x7FFF and 0xA000–0xBFFF go to the cartridge port for reads and writes. A write there raises `cart_we_o`, with the address on `mem_addr_o` and the data byte on `mem_wdata_o`. This also applies to 0x0000–0x00FF while the boot overlay is active.
- R2: The router sends 0x8000–0x9FFF to video memory, 0xC000–0xCFFF to work-RAM bank 0, 0xD000–0xDFFF to work-RAM bank 1 and 0xFF80–0xFFFE to high RAM. A read returns that port's data and a write raises that port's strobe.
- R3: Reset makes the boot overlay active. While it is active, a read in 0x0000–0x00FF returns `boot_rdata_i` and does not return cartridge data.
- R4: A write of any nonzero byte to 0xFF50 turns the overlay off. A write of zero leaves it unchanged. Only reset turns the overlay back on. A read of 0xFF50 is refused as in R8.
- R5: The interrupt-enable register sits at 0xFFFF and resets to 0. A write updates it, and the new value is visible on `irq_en_o` after the clock edge. A read returns it.
- R6: A read of 0xFF0F returns bit 0 from `vid_vblank_i` and bit 1 from `vid_stat_i`, both taken live. Bits 7:2 come from the stored register, which resets to 0. `irq_flag_o` always shows this merged value.
- R7: A write to 0xFF0F stores bits 7:2. In the same cycle it raises `vid_irq_we_o` and drives `vid_vblank_o` with data bit 0 and `vid_stat_o` with data bit 1.
- R8: An access to 0xE000–0xFEFF raises `bus_err_o` in the access cycle. A read there returns 0xFF, and a write raises no strobe and changes no state.
- R9: In 0xFF00–0xFF7F, only the following low bytes reach the peripheral port: 01, 02, 07, 11–14, 24–26, 40–45 and 47–4B. Reads return `io_rdata_i` and writes raise `io_we_o`. Every other address in the window is refused as in R8, except 0x0F (R6, R7) and a write to 0x50 (R4).
- R10: A write raises at most one strobe among the cartridge, video, work-RAM 0, work-RAM 1, high-RAM, peripheral and video-interrupt strobes. It is high for exactly the one access cycle. A read raises none.
- R11: A word read takes two cycles. In the first, `ready_o` is low and `mem_addr_o` is addr+1, wrapping at 0xFFFF. In the second, `mem_addr_o` is addr, `ready_o` is high and `rdata_o` holds the byte at addr+1 in bits 15:8 and the byte at addr in bits 7:0. A byte read returns its byte in bits 7:0 with bits 15:8 zero and `ready_o` high.
- R12: A word write puts `wdata_i[15:8]` to addr+1 in the first cycle and `wdata_i[7:0]` to addr in the second. Each byte follows the routing and state rules of R1–R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until `ready_o` |
| we_i | input | 1 | 1 = write, 0 = read |
| word_i | input | 1 | 1 = 16-bit access, 0 = byte access |
| addr_i | input | 16 | Access address |
| wdata_i | input | 16 | Write data; bits 7:0 for byte writes |
| rdata_o | output | 16 | Read data |
| ready_o | output | 1 | Access completes this cycle |
| bus_err_o | output | 1 | Refused access in this cycle |
| mem_addr_o | output | 16 | Byte address for the current cycle |
| mem_wdata_o | output | 8 | Byte write data for the current cycle |
| cart_we_o | output | 1 | Cartridge write strobe |
| cart_rdata_i | input | 8 | Cartridge read data |
| boot_rdata_i | input | 8 | Boot ROM read data |
| vram_we_o | output | 1 | Video memory write strobe |
| vram_rdata_i | input | 8 | Video memory read data |
| wram0_we_o | output | 1 | Work-RAM bank 0 write strobe |
| wram0_rdata_i | input | 8 | Work-RAM bank 0 read data |
| wram1_we_o | output | 1 | Work-RAM bank 1 write strobe |
| wram1_rdata_i | input | 8 | Work-RAM bank 1 read data |
| hram_we_o | output | 1 | High-RAM write strobe |
| hram_rdata_i | input | 8 | High-RAM read data |
| io_we_o | output | 1 | Peripheral register write strobe |
| io_rdata_i | input | 8 | Peripheral register read data |
| irq_en_o | output | 8 | Interrupt-enable register |
| irq_flag_o | output | 8 | Merged interrupt-flag value |
| vid_vblank_i | input | 1 | Live vertical-blank request from the video unit |
| vid_stat_i | input | 1 | Live status request from the video unit |
| vid_irq_we_o | output | 1 | Flag write toward the video unit |
| vid_vblank_o | output | 1 | Vertical-blank bit value written |
| vid_stat_o | output | 1 | Status bit value written |

## Verification
The hardest state to reach from the ports is a change of state in the middle of a word access. Examples are a word write whose high byte lands on 0xFF50 or 0xFFFF while its low byte lands in another region, and a word read that straddles the boundary of a forbidden region or wraps from 0xFFFF to 0x0000. The random stimulus draws addresses by region class, with extra weight on the boundaries and on the single-address registers, and picks byte or word width at random. The overlay-disable address is drawn rarely, so overlay reads are exercised before the latch closes. Directed steps then cover zero and nonzero writes to 0xFF50, and a reset in the middle of the run that restores the overlay.

// File: rtl/mem_router_pkg.sv
package mem_router_pkg;
  localparam int unsigned ADDR_W = 16;

  typedef enum logic [3:0] {
    RG_CART, RG_BOOT, RG_VRAM, RG_WRAM0, RG_WRAM1, RG_HRAM,
    RG_IE, RG_IF, RG_BOOTOFF, RG_IO, RG_BAD
  } region_e;

  function automatic logic io_known(input logic [7:0] lo);
    case (lo)
      8'h01, 8'h02, 8'h07,
      8'h11, 8'h12, 8'h13, 8'h14,
      8'h24, 8'h25, 8'h26,
      8'h40, 8'h41, 8'h42, 8'h43, 8'h44, 8'h45,
      8'h47, 8'h48, 8'h49, 8'h4A, 8'h4B: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/addr_decode.sv
module addr_decode
  import mem_router_pkg::*;
#(
  parameter int unsigned BOOT_BYTES = 256
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              boot_on_i,
  output region_e           region_o
);
  localparam logic [ADDR_W-1:0] BootEnd = ADDR_W'(BOOT_BYTES);

  always_comb begin
    region_o = RG_BAD;
    if (addr_i <= 16'h7FFF)
      region_o = (!we_i && boot_on_i && addr_i < BootEnd) ? RG_BOOT : RG_CART;
    else if (addr_i <= 16'h9FFF) region_o = RG_VRAM;
    else if (addr_i <= 16'hBFFF) region_o = RG_CART;
    else if (addr_i <= 16'hCFFF) region_o = RG_WRAM0;
    else if (addr_i <= 16'hDFFF) region_o = RG_WRAM1;
    else if (addr_i <= 16'hFEFF) region_o = RG_BAD;
    else if (addr_i <= 16'hFF7F) begin
      if (addr_i[7:0] == 8'h0F)      region_o = RG_IF;
      else if (addr_i[7:0] == 8'h50) region_o = we_i ? RG_BOOTOFF : RG_BAD;
      else if (io_known(addr_i[7:0])) region_o = RG_IO;
      else                            region_o = RG_BAD;
    end
    else if (addr_i == 16'hFFFF) region_o = RG_IE;
    else region_o = RG_HRAM;
  end
endmodule

// File: rtl/word_seq.sv
module word_seq
  import mem_router_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              word_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     byte_rdata_i,
  output logic [ADDR_W-1:0] byte_addr_o,
  output logic              hi_phase_o,
  output logic              ready_o,
  output logic [2*DW-1:0]   rdata_o
);
  logic          phase_q;
  logic [DW-1:0] hi_q;

  assign hi_phase_o  = req_i & word_i & ~phase_q;
  assign byte_addr_o = hi_phase_o ? addr_i + ADDR_W'(1) : addr_i;
  assign ready_o     = req_i & (~word_i | phase_q);
  assign rdata_o     = word_i ? {hi_q, byte_rdata_i} : {{DW{1'b0}}, byte_rdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      hi_q    <= '0;
    end else if (hi_phase_o) begin
      phase_q <= 1'b1;
      hi_q    <= byte_rdata_i;
    end else begin
      phase_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sys_regs.sv
module sys_regs
  import mem_router_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  region_e       region_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          vid_vblank_i,
  input  logic          vid_stat_i,
  output logic          boot_on_o,
  output logic [DW-1:0] ie_o,
  output logic [DW-1:0] if_o,
  output logic          vid_wr_o,
  output logic          vid_vblank_o,
  output logic          vid_stat_o
);
  logic [DW-1:2] if_q;

  // bits 1:0 are owned by the video unit; read live
  assign if_o         = {if_q, vid_stat_i, vid_vblank_i};
  assign vid_wr_o     = wr_i & (region_i == RG_IF);
  assign vid_vblank_o = wdata_i[0];
  assign vid_stat_o   = wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_on_o <= 1'b1;
      ie_o      <= '0;
      if_q      <= '0;
    end else if (wr_i) begin
      if (region_i == RG_IE) ie_o <= wdata_i;
      if (region_i == RG_IF) if_q <= wdata_i[DW-1:2];
      if (region_i == RG_BOOTOFF && |wdata_i) boot_on_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mem_router.sv
module mem_router
  import mem_router_pkg::*;
#(
  parameter int unsigned DW         = 8,
  parameter int unsigned BOOT_BYTES = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              word_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2*DW-1:0]   wdata_i,
  output logic [2*DW-1:0]   rdata_o,
  output logic              ready_o,
  output logic              bus_err_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic              cart_we_o,
  input  logic [DW-1:0]     cart_rdata_i,
  input  logic [DW-1:0]     boot_rdata_i,
  output logic              vram_we_o,
  input  logic [DW-1:0]     vram_rdata_i,
  output logic              wram0_we_o,
  input  logic [DW-1:0]     wram0_rdata_i,
  output logic              wram1_we_o,
  input  logic [DW-1:0]     wram1_rdata_i,
  output logic              hram_we_o,
  input  logic [DW-1:0]     hram_rdata_i,
  output logic              io_we_o,
  input  logic [DW-1:0]     io_rdata_i,
  output logic [DW-1:0]     irq_en_o,
  output logic [DW-1:0]     irq_flag_o,
  input  logic              vid_vblank_i,
  input  logic              vid_stat_i,
  output logic              vid_irq_we_o,
  output logic              vid_vblank_o,
  output logic              vid_stat_o
);
  region_e       region;
  logic          hi_phase;
  logic          boot_on;
  logic          wr;
  logic [DW-1:0] byte_rd;

  assign wr          = req_i & we_i;
  assign mem_wdata_o = hi_phase ? wdata_i[2*DW-1:DW] : wdata_i[DW-1:0];
  assign bus_err_o   = req_i & (region == RG_BAD);

  word_seq #(.DW(DW)) u_seq (
    .clk_i, .rst_ni, .req_i, .word_i, .addr_i,
    .byte_rdata_i (byte_rd),
    .byte_addr_o  (mem_addr_o),
    .hi_phase_o   (hi_phase),
    .ready_o,
    .rdata_o
  );

  addr_decode #(.BOOT_BYTES(BOOT_BYTES)) u_dec (
    .addr_i    (mem_addr_o),
    .we_i,
    .boot_on_i (boot_on),
    .region_o  (region)
  );

  sys_regs #(.DW(DW)) u_regs (
    .clk_i, .rst_ni,
    .wr_i         (wr),
    .region_i     (region),
    .wdata_i      (mem_wdata_o),
    .vid_vblank_i, .vid_stat_i,
    .boot_on_o    (boot_on),
    .ie_o         (irq_en_o),
    .if_o         (irq_flag_o),
    .vid_wr_o     (vid_irq_we_o),
    .vid_vblank_o, .vid_stat_o
  );

  always_comb begin
    case (region)
      RG_CART:  byte_rd = cart_rdata_i;
      RG_BOOT:  byte_rd = boot_rdata_i;
      RG_VRAM:  byte_rd = vram_rdata_i;
      RG_WRAM0: byte_rd = wram0_rdata_i;
      RG_WRAM1: byte_rd = wram1_rdata_i;
      RG_HRAM:  byte_rd = hram_rdata_i;
      RG_IO:    byte_rd = io_rdata_i;
      RG_IE:    byte_rd = irq_en_o;
      RG_IF:    byte_rd = irq_flag_o;
      default:  byte_rd = '1;
    endcase
  end

  assign cart_we_o  = wr & (region == RG_CART);
  assign vram_we_o  = wr & (region == RG_VRAM);
  assign wram0_we_o = wr & (region == RG_WRAM0);
  assign wram1_we_o = wr & (region == RG_WRAM1);
  assign hram_we_o  = wr & (region == RG_HRAM);
  assign io_we_o    = wr & (region == RG_IO);
endmodule

// File: rtl/mem_router_chk.sv
module mem_router_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic        word_i,
  input logic [15:0] addr_i,
  input logic [15:0] wdata_i,
  input logic [15:0] rdata_o,
  input logic        ready_o,
  input logic        bus_err_o,
  input logic [7:0]  mem_wdata_o,
  input logic [6:0]  strobes,
  input logic [7:0]  irq_en_o,
  input logic [7:0]  irq_flag_o,
  input logic        vid_vblank_i,
  input logic        vid_stat_i,
  input logic        vid_irq_we_o,
  input logic        vid_vblank_o,
  input logic        vid_stat_o,
  input logic        boot_on
);
  assert_one_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strobes));

  assert_read_silent_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |-> strobes == 7'b0);

  assert_boot_oneway_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boot_on |=> !boot_on);

  assert_err_silent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> (strobes == 7'b0) && (we_i || rdata_o[7:0] == 8'hFF));

  assert_ie_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !word_i && addr_i == 16'hFFFF) |=> irq_en_o == $past(wdata_i[7:0]));

  assert_if_live_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_flag_o[1:0] == {vid_stat_i, vid_vblank_i});

  assert_vid_sync_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_irq_we_o |-> (vid_vblank_o == mem_wdata_o[0]) && (vid_stat_o == mem_wdata_o[1]));

  assert_word_two_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && word_i && !ready_o) |=> (!req_i || !word_i || ready_o));
endmodule

bind mem_router mem_router_chk u_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .word_i, .addr_i, .wdata_i, .rdata_o,
  .ready_o, .bus_err_o, .mem_wdata_o,
  .strobes ({cart_we_o, vram_we_o, wram0_we_o, wram1_we_o, hram_we_o, io_we_o, vid_irq_we_o}),
  .irq_en_o, .irq_flag_o, .vid_vblank_i, .vid_stat_i,
  .vid_irq_we_o, .vid_vblank_o, .vid_stat_o,
  .boot_on (boot_on)
);

// File: tb/sim_mem_router.sv
module sim_mem_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, word = 1'b0;
  logic [15:0] addr = '0, wdata = '0, rdata, mem_addr;
  logic        ready, bus_err, vb = 1'b0, st = 1'b0;
  logic [7:0]  mem_wdata, irq_en, irq_flag;
  logic        cart_we, vram_we, wram0_we, wram1_we, hram_we, io_we;
  logic        vid_we, vid_vb_o, vid_st_o;
  logic [7:0]  cart_rd, boot_rd, vram_rd, w0_rd, w1_rd, hram_rd, io_rd;

  int unsigned n_chk = 0, n_fail = 0;
  bit          boot_m;
  logic [7:0]  ie_m, if_m;

  always #2 clk = ~clk;

  assign cart_rd = mem_addr[7:0] ^ 8'hC3;
  assign boot_rd = mem_addr[7:0] + 8'h77;
  assign vram_rd = mem_addr[7:0] + 8'h10;
  assign w0_rd   = mem_addr[7:0] ^ 8'h5A;
  assign w1_rd   = mem_addr[7:0] ^ 8'hA5;
  assign hram_rd = ~mem_addr[7:0];
  assign io_rd   = mem_addr[7:0] ^ 8'h3C;

  mem_router u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .word_i(word),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready),
    .bus_err_o(bus_err), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .cart_we_o(cart_we), .cart_rdata_i(cart_rd), .boot_rdata_i(boot_rd),
    .vram_we_o(vram_we), .vram_rdata_i(vram_rd),
    .wram0_we_o(wram0_we), .wram0_rdata_i(w0_rd),
    .wram1_we_o(wram1_we), .wram1_rdata_i(w1_rd),
    .hram_we_o(hram_we), .hram_rdata_i(hram_rd),
    .io_we_o(io_we), .io_rdata_i(io_rd),
    .irq_en_o(irq_en), .irq_flag_o(irq_flag),
    .vid_vblank_i(vb), .vid_stat_i(st),
    .vid_irq_we_o(vid_we), .vid_vblank_o(vid_vb_o), .vid_stat_o(vid_st_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit io_ok(input logic [7:0] lo);
    return (lo == 8'h01) || (lo == 8'h02) || (lo == 8'h07) ||
           (lo >= 8'h11 && lo <= 8'h14) || (lo >= 8'h24 && lo <= 8'h26) ||
           (lo >= 8'h40 && lo <= 8'h45) || (lo >= 8'h47 && lo <= 8'h4B);
  endfunction

  // {err, data}
  function automatic logic [8:0] exp_rd(input logic [15:0] a);
    if (a < 16'h0100 && boot_m)      return {1'b0, a[7:0] + 8'h77};
    if (a <= 16'h7FFF)               return {1'b0, a[7:0] ^ 8'hC3};
    if (a <= 16'h9FFF)               return {1'b0, a[7:0] + 8'h10};
    if (a <= 16'hBFFF)               return {1'b0, a[7:0] ^ 8'hC3};
    if (a <= 16'hCFFF)               return {1'b0, a[7:0] ^ 8'h5A};
    if (a <= 16'hDFFF)               return {1'b0, a[7:0] ^ 8'hA5};
    if (a <= 16'hFEFF)               return {1'b1, 8'hFF};
    if (a == 16'hFF0F)               return {1'b0, if_m[7:2], st, vb};
    if (a <= 16'hFF7F)               return io_ok(a[7:0]) ? {1'b0, a[7:0] ^ 8'h3C} : {1'b1, 8'hFF};
    if (a == 16'hFFFF)               return {1'b0, ie_m};
    return {1'b0, ~a[7:0]};
  endfunction

  // {cart, vram, wram0, wram1, hram, io, vid}
  function automatic logic [6:0] exp_st(input logic [15:0] a);
    if (a <= 16'h7FFF) return 7'b1000000;
    if (a <= 16'h9FFF) return 7'b0100000;
    if (a <= 16'hBFFF) return 7'b1000000;
    if (a <= 16'hCFFF) return 7'b0010000;
    if (a <= 16'hDFFF) return 7'b0001000;
    if (a <= 16'hFEFF) return 7'b0;
    if (a == 16'hFF0F) return 7'b0000001;
    if (a <= 16'hFF7F) return io_ok(a[7:0]) ? 7'b0000010 : 7'b0;
    if (a == 16'hFFFF) return 7'b0;
    return 7'b0000100;
  endfunction

  function automatic bit exp_err_w(input logic [15:0] a);
    if (a >= 16'hE000 && a <= 16'hFEFF) return 1'b1;
    if (a >= 16'hFF00 && a <= 16'hFF7F && a != 16'hFF0F && a != 16'hFF50 && !io_ok(a[7:0])) return 1'b1;
    return 1'b0;
  endfunction

  function automatic string tag_of(input logic [15:0] a);
    if (a < 16'h0100) return "R3";
    if (a <= 16'h7FFF || (a >= 16'hA000 && a <= 16'hBFFF)) return "R1";
    if (a >= 16'hE000 && a <= 16'hFEFF) return "R8";
    if (a == 16'hFF0F) return "R6";
    if (a == 16'hFF50) return "R4";
    if (a == 16'hFFFF) return "R5";
    if (a >= 16'hFF00 && a <= 16'hFF7F) return "R9";
    return "R2";
  endfunction

  function automatic logic [6:0] strb();
    return {cart_we, vram_we, wram0_we, wram1_we, hram_we, io_we, vid_we};
  endfunction

  // check one byte cycle; outputs already settled
  task automatic chk_cycle(input bit w, input logic [15:0] a, input logic [7:0] d, input bit is_word);
    logic [8:0] e;
    e = exp_rd(a);
    chk(mem_addr == a, is_word ? "R11" : tag_of(a), mem_addr, a);
    if (w) begin
      chk(bus_err == exp_err_w(a), "R8", 16'(bus_err), 16'(exp_err_w(a)));
      chk(strb() == exp_st(a), is_word ? "R12" : "R10", 16'(strb()), 16'(exp_st(a)));
      if (exp_st(a) != 7'b0) chk(mem_wdata == d, is_word ? "R12" : "R1", 16'(mem_wdata), 16'(d));
      if (a == 16'hFF0F) chk({vid_st_o, vid_vb_o} == d[1:0], "R7", 16'({vid_st_o, vid_vb_o}), 16'(d[1:0]));
    end else begin
      chk(bus_err == e[8], e[8] ? "R8" : tag_of(a), 16'(bus_err), 16'(e[8]));
      chk(strb() == 7'b0, "R10", 16'(strb()), 16'h0);
    end
  endtask

  task automatic apply_wr(input logic [15:0] a, input logic [7:0] d);
    if (a == 16'hFFFF) begin
      ie_m = d;
      chk(irq_en == d, "R5", 16'(irq_en), 16'(d));
    end
    if (a == 16'hFF0F) if_m = d;
    if (a == 16'hFF50 && d != 8'h00) boot_m = 1'b0;
  endtask

  task automatic byte_acc(input bit w, input logic [15:0] a, input logic [7:0] d);
    logic [8:0] e;
    @(negedge clk);
    req = 1'b1; we = w; word = 1'b0; addr = a; wdata = {8'h00, d};
    vb = 1'($urandom); st = 1'($urandom);
    #1;
    chk_cycle(w, a, d, 1'b0);
    chk(ready == 1'b1, "R11", 16'(ready), 16'h1);
    if (!w) begin
      e = exp_rd(a);
      chk(rdata == {8'h00, e[7:0]}, e[8] ? "R8" : tag_of(a), rdata, {8'h00, e[7:0]});
    end
    @(posedge clk); #1;
    if (w) apply_wr(a, d);
  endtask

  task automatic word_acc(input bit w, input logic [15:0] a, input logic [15:0] d);
    logic [15:0] a1;
    logic [8:0]  eh, el;
    a1 = a + 16'd1;
    @(negedge clk);
    req = 1'b1; we = w; word = 1'b1; addr = a; wdata = d;
    vb = 1'($urandom); st = 1'($urandom);
    #1;
    eh = exp_rd(a1);
    chk(ready == 1'b0, "R11", 16'(ready), 16'h0);
    chk_cycle(w, a1, d[15:8], 1'b1);
    @(posedge clk); #1;
    if (w) apply_wr(a1, d[15:8]);
    el = exp_rd(a);
    chk(ready == 1'b1, "R11", 16'(ready), 16'h1);
    chk_cycle(w, a, d[7:0], 1'b1);
    if (!w) chk(rdata == {eh[7:0], el[7:0]}, "R11", rdata, {eh[7:0], el[7:0]});
    @(posedge clk); #1;
    if (w) apply_wr(a, d[7:0]);
  endtask

  task automatic idle();
    @(negedge clk);
    req = 1'b0; we = 1'b0; word = 1'b0;
    #1;
    chk(strb() == 7'b0 && !bus_err, "R10", 16'({strb(), bus_err}), 16'h0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    req = 1'b0; rst_n = 1'b0;
    boot_m = 1'b1; ie_m = 8'h00; if_m = 8'h00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(irq_en == 8'h00, "R5", 16'(irq_en), 16'h0);
    chk(irq_flag[7:2] == 6'h0, "R6", 16'(irq_flag), 16'h0);
  endtask

  function automatic logic [15:0] pick_addr(input logic [31:0] r1, input logic [31:0] r2);
    case (r1 % 13)
      0:  return {1'b0, r2[14:0]};
      1:  return {8'h00, r2[7:0]};
      2:  return 16'h8000 + {3'b0, r2[12:0]};
      3:  return 16'hA000 + {3'b0, r2[12:0]};
      4:  return 16'hC000 + {4'b0, r2[11:0]};
      5:  return 16'hD000 + {4'b0, r2[11:0]};
      6:  return 16'hE000 + 16'(r2 % 32'h1F00);
      7:  return 16'hFF00 + {9'b0, r2[6:0]};
      8:  return 16'hFF80 + {9'b0, r2[6:0]};
      9:  return 16'hFFFF;
      10: return 16'hFF0F;
      11: return (r2[4:0] == 5'd0) ? 16'hFF50 : 16'hFF40 + {12'b0, r2[3:0]};
      default: return (r2[0]) ? 16'hDFFF : 16'hFEFF;
    endcase
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1729));
    do_reset();
    // R3: overlay after reset; writes under it still reach the cartridge (R1)
    byte_acc(1'b0, 16'h0000, 8'h00);
    byte_acc(1'b0, 16'h00FF, 8'h00);
    byte_acc(1'b0, 16'h0100, 8'h00);
    byte_acc(1'b1, 16'h0042, 8'h9E);
    // R6/R7: flag bits shared with video
    byte_acc(1'b1, 16'hFF0F, 8'hFD);
    byte_acc(1'b0, 16'hFF0F, 8'h00);
    byte_acc(1'b1, 16'hFFFF, 8'h1F);
    byte_acc(1'b0, 16'hFFFF, 8'h00);
    // R8/R9 boundaries
    byte_acc(1'b0, 16'hE000, 8'h00);
    byte_acc(1'b1, 16'hFEFF, 8'h55);
    byte_acc(1'b0, 16'hFF03, 8'h00);
    byte_acc(1'b0, 16'hFF4B, 8'h00);
    byte_acc(1'b0, 16'hFF50, 8'h00);
    // R11/R12 wrap and straddle
    word_acc(1'b0, 16'hFFFF, 16'h0);
    word_acc(1'b0, 16'hDFFF, 16'h0);
    word_acc(1'b1, 16'hFFFE, 16'hA55A);
    byte_acc(1'b0, 16'hFFFF, 8'h00);
    // R4: zero keeps overlay
    byte_acc(1'b1, 16'hFF50, 8'h00);
    byte_acc(1'b0, 16'h0010, 8'h00);
    idle();
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      a = pick_addr($urandom, $urandom);
      if ($urandom % 4 == 0) word_acc(1'($urandom), a, 16'($urandom));
      else                   byte_acc(1'($urandom), a, 8'($urandom));
      if (i % 100 == 0) idle();
    end
    // R4: nonzero write closes overlay, reset reopens
    byte_acc(1'b1, 16'hFF50, 8'h01);
    byte_acc(1'b0, 16'h0010, 8'h00);
    byte_acc(1'b1, 16'hFF50, 8'h00);
    byte_acc(1'b0, 16'h0020, 8'h00);
    idle();
    do_reset();
    byte_acc(1'b0, 16'h0010, 8'h00);
    idle();
    finish_run();
  end
endmodule